// File: doc/BRIEF.md
# Timed Page-Write Engine for a Byte-Wide EEPROM Array

This block is a synchronous model of the write path of a byte-wide EEPROM. A bus master issues single-cycle byte-write strobes, each with an address and a data byte. The address splits into a page number (upper bits) and a byte index within the page (lower `PAGE_BITS` bits). The first accepted byte opens a page. Later strobes to the same page are gathered into a page buffer. Every accepted byte restarts an inactivity timer. When `LOAD_TIMEOUT` cycles pass with no further accepted byte, a fixed-length internal program cycle of `WRITE_CYCLES` cycles begins. At the end of that cycle the buffered bytes are copied into the register array in one step.

While a page is loading or being programmed, a read does not return array data. It returns a status byte instead. During the program cycle `ready` is held low, so software can poll the status byte or watch the pin. The array depth is `2**ADDR_W` bytes. The default is a 2K x 8 array with 64-byte pages; an 8K x 8 array is obtained with `ADDR_W = 13`.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset the array holds 0xFF in every byte, `ready` is 1 and `rdata_oe` is 0x00.
- R2: A read accepted while no page is loading or programming returns the addressed array byte on `rdata`, with `rdata_oe` = 0xFF, one cycle after `rd_en`.
- R3: At the end of the program cycle, every byte of the open page that was loaded takes its most recently loaded value. Bytes of that page that were not loaded keep their previous contents. Page = `addr[ADDR_W-1:PAGE_BITS]`, byte index = `addr[PAGE_BITS-1:0]`.
- R4: The program cycle begins (`ready` falls) exactly `LOAD_TIMEOUT` cycles after the edge that accepted the last byte, and each accepted byte restarts that count.
- R5: While a page is loading, a write strobe carrying a different page number is ignored. It neither stores data nor restarts the timer.
- R6: `ready` stays low for exactly `WRITE_CYCLES` cycles. Write strobes during that time are ignored and do not open a new page.
- R7: Status bit 5 reads 0 while the load timer runs and 1 during the program cycle.
- R8: Status bit 7 reads the inverse of bit 7 of the last accepted byte while loading or programming. After completion, a read returns the true stored value.
- R9: During the program cycle, status bit 6 reads 0 on the first read and inverts on each later read. Once programming ends, reads return array data.
- R10: A status read drives `rdata_oe` = 0xE0 (bits 7..5 driven) and returns zero in bits 4..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte-write strobe |
| addr | input | ADDR_W | Byte address for writes and reads |
| wdata | input | DATA_W | Write data byte |
| rd_en | input | 1 | Read strobe; result appears the next cycle |
| rdata | output | DATA_W | Read result: array byte or status byte |
| rdata_oe | output | DATA_W | Per-bit mask of driven read bits |
| ready | output | 1 | Low during the internal program cycle |

## Verification
The in-RTL properties check the following on every cycle:
- the length of every busy window;
- the driven-bit mask and zero low bits of every status read;
- the page-load bit against the current phase;
- the alternation of the toggle bit across back-to-back program-phase reads, and its zero start;
- that the open page never changes mid-burst.

Only the bench scenarios can show the following:
- what the array holds after a commit, including the merge of loaded bytes with untouched ones and overwrite-with-latest;
- the exact distance from the last accepted byte to the start of programming;
- that foreign-page and busy-time strobes leave no trace in either the data or the timing.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } eepw_state_t;

   localparam int STAT_POLL_BIT = 7;
   localparam int STAT_TOG_BIT  = 6;
   localparam int STAT_TMR_BIT  = 5;
   localparam logic [7:0] STAT_OE_MASK = 8'hE0;
endpackage

// File: rtl/eepw_countdown.sv
module eepw_countdown #(
   parameter int COUNT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic done
);
   localparam int CW = (COUNT < 2) ? 1 : $clog2(COUNT + 1);
   localparam logic [CW-1:0] RELOAD = CW'(COUNT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= RELOAD;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [PAGE_BITS-1:0]         idx,
   input  logic [DATA_W-1:0]            din,
   input  logic                         clear,
   output logic [(1<<PAGE_BITS)*DATA_W-1:0] bytes_o,
   output logic [(1<<PAGE_BITS)-1:0]    valid_o
);
   localparam int PAGE_SZ = 1 << PAGE_BITS;

   for (genvar g = 0; g < PAGE_SZ; g++) begin : g_slot
      logic [DATA_W-1:0] data_q;
      logic              vld_q;
      wire               hit = load && (idx == PAGE_BITS'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
         end else if (clear) begin
            vld_q  <= 1'b0;
         end else if (hit) begin
            data_q <= din;
            vld_q  <= 1'b1;
         end
      end

      assign bytes_o[g*DATA_W +: DATA_W] = data_q;
      assign valid_o[g] = vld_q;
   end
endmodule

// File: rtl/eepw_array.sv
module eepw_array #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              commit,
   input  logic [ADDR_W-PAGE_BITS-1:0]       commit_pg,
   input  logic [(1<<PAGE_BITS)*DATA_W-1:0]  page_bytes,
   input  logic [(1<<PAGE_BITS)-1:0]         page_valid,
   input  logic [ADDR_W-1:0]                 rd_addr,
   output logic [DATA_W-1:0]                 rd_byte
);
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int PAGE_SZ = 1 << PAGE_BITS;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      end else if (commit) begin
         for (int i = 0; i < PAGE_SZ; i++) begin
            if (page_valid[i]) begin
               mem_q[{commit_pg, PAGE_BITS'(i)}] <= page_bytes[i*DATA_W +: DATA_W];
            end
         end
      end
   end

   assign rd_byte = mem_q[rd_addr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 8,
   parameter int PAGE_BITS    = 6,
   parameter int LOAD_TIMEOUT = 200,
   parameter int WRITE_CYCLES = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] rdata_oe,
   output logic              ready
);
   import eepw_pkg::*;

   localparam int PAGE_SZ = 1 << PAGE_BITS;
   localparam int PG_W    = ADDR_W - PAGE_BITS;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("eeprom_page_writer: status layout needs DATA_W == 8");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("eeprom_page_writer: PAGE_BITS must be within 1..ADDR_W-1");
   end
   if (LOAD_TIMEOUT < 1 || WRITE_CYCLES < 1) begin : g_bad_time
      $error("eeprom_page_writer: timer lengths must be at least 1");
   end

   eepw_state_t     state_q, state_d;
   logic [PG_W-1:0] open_pg_q;
   logic            last_msb_q;
   logic            tog_q;

   wire [PG_W-1:0]      req_pg  = addr[ADDR_W-1:PAGE_BITS];
   wire [PAGE_BITS-1:0] req_idx = addr[PAGE_BITS-1:0];

   logic accept, load_done, prog_done, start_prog, commit;
   logic [PAGE_SZ*DATA_W-1:0] buf_bytes;
   logic [PAGE_SZ-1:0]        buf_valid;
   logic [DATA_W-1:0]         arr_byte;
   logic [DATA_W-1:0]         status_byte;

   assign accept = wr_en && ((state_q == ST_IDLE) ||
                             ((state_q == ST_LOAD) && (req_pg == open_pg_q)));
   assign start_prog = (state_q == ST_LOAD) && !accept && load_done;
   assign commit     = (state_q == ST_PROG) && prog_done;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept)     state_d = ST_LOAD;
         ST_LOAD: if (start_prog) state_d = ST_PROG;
         ST_PROG: if (commit)     state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         open_pg_q  <= '0;
         last_msb_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            open_pg_q  <= req_pg;
            last_msb_q <= wdata[DATA_W-1];
         end
      end
   end

   eepw_countdown #(.COUNT(LOAD_TIMEOUT)) u_load_tmr (
      .clk(clk), .rst_n(rst_n), .restart(accept),
      .run(state_q == ST_LOAD), .done(load_done)
   );

   eepw_countdown #(.COUNT(WRITE_CYCLES)) u_prog_tmr (
      .clk(clk), .rst_n(rst_n), .restart(start_prog),
      .run(state_q == ST_PROG), .done(prog_done)
   );

   eepw_page_buf #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_buf (
      .clk(clk), .rst_n(rst_n), .load(accept), .idx(req_idx), .din(wdata),
      .clear(commit), .bytes_o(buf_bytes), .valid_o(buf_valid)
   );

   eepw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_arr (
      .clk(clk), .rst_n(rst_n), .commit(commit), .commit_pg(open_pg_q),
      .page_bytes(buf_bytes), .page_valid(buf_valid),
      .rd_addr(addr), .rd_byte(arr_byte)
   );

   // Status byte: polling, toggle and load-timer bits; low bits undriven.
   always_comb begin
      status_byte                = '0;
      status_byte[STAT_POLL_BIT] = ~last_msb_q;
      status_byte[STAT_TOG_BIT]  = (state_q == ST_PROG) ? tog_q : 1'b0;
      status_byte[STAT_TMR_BIT]  = (state_q == ST_PROG);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if (state_q != ST_PROG) begin
         tog_q <= 1'b0;
      end else if (rd_en) begin
         tog_q <= ~tog_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         rdata_oe <= '0;
      end else if (rd_en) begin
         if (state_q == ST_IDLE) begin
            rdata    <= arr_byte;
            rdata_oe <= '1;
         end else begin
            rdata    <= status_byte;
            rdata_oe <= STAT_OE_MASK;
         end
      end
   end

   assign ready = (state_q != ST_PROG);

   // Busy-window length counter used by the checks below.
   logic [31:0] chk_busy_q;
   always_ff @(posedge clk) begin
      if (!rst_n || ready) chk_busy_q <= '0;
      else                 chk_busy_q <= chk_busy_q + 1;
   end

   assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (chk_busy_q == 32'(WRITE_CYCLES)));

   assert_status_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (state_q != ST_IDLE)) |=> ((rdata_oe == STAT_OE_MASK) && (rdata[4:0] == 5'd0)));

   assert_timer_bit_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (state_q == ST_LOAD)) |=> !rdata[STAT_TMR_BIT]);

   assert_timer_bit_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (state_q == ST_PROG)) |=> rdata[STAT_TMR_BIT]);

   assert_toggle_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (state_q == ST_PROG) && ($past(state_q) == ST_LOAD)) |=> !rdata[STAT_TOG_BIT]);

   assert_toggle_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (state_q == ST_PROG) && $past(rd_en && (state_q == ST_PROG)))
      |=> (rdata[STAT_TOG_BIT] != $past(rdata[STAT_TOG_BIT])));

   assert_page_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_LOAD) && ($past(state_q) == ST_LOAD)) |-> (open_pg_q == $past(open_pg_q)));
endmodule

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int PB = 3;
   localparam int LT = 6;
   localparam int WC = 20;
   localparam int DEPTH = 1 << AW;
   localparam int PSZ = 1 << PB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata, rdata_oe;
   logic          ready;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] model [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_page_writer #(.ADDR_W(AW), .DATA_W(8), .PAGE_BITS(PB),
                        .LOAD_TIMEOUT(LT), .WRITE_CYCLES(WC)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .rdata_oe(rdata_oe), .ready(ready)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; addr = AW'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d, output logic [7:0] oe);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata; oe = rdata_oe;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (ready && n < 200) begin @(negedge clk); n++; end
      while (!ready && n < 400) begin @(negedge clk); n++; end
   endtask

   task automatic read_cmp(input int a, input string tag);
      logic [7:0] d, oe;
      rd(a, d, oe);
      check(tag, {d, oe}, {model[a], 8'hFF});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d, oe;
      int c, b;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 ready", ready, 1);
      check("R1 oe", rdata_oe, 0);
      // R1/R2: every byte reads 0xFF with full mask
      for (int a = 0; a < DEPTH; a++) read_cmp(a, "R1 R2 erased sweep");

      // R3/R5/R7/R8/R10: burst into page 3 with a repeat and a foreign strobe
      wr(24, 8'h5A); wr(26, 8'h13); wr(29, 8'hC4); wr(26, 8'h99);
      wr(33, 8'h77);  // page 4, ignored (R5)
      model[24] = 8'h5A; model[26] = 8'h99; model[29] = 8'hC4;
      rd(24, d, oe);
      check("R7 R8 load status", d, 8'h00);
      check("R10 load mask", oe, 8'hE0);
      wait_idle();
      for (int a = 24; a < 40; a++) read_cmp(a, "R3 R5 page contents");

      // R4/R6: timer restart and busy length
      wr(56, 8'h01);
      repeat (2) @(negedge clk);
      wr(57, 8'h02);
      model[56] = 8'h01; model[57] = 8'h02;
      c = 0;
      while (ready && c < 100) begin @(negedge clk); c++; end
      check("R4 restart to busy", c, LT);
      b = 0;
      while (!ready && b < 100) begin @(negedge clk); b++; end
      check("R6 busy length", b, WC);
      read_cmp(56, "R4 data"); read_cmp(57, "R4 data");

      // R5: foreign strobe does not restart the timer
      wr(64, 8'h10);
      repeat (2) @(negedge clk);
      wr(80, 8'h20);
      model[64] = 8'h10;
      c = 3;
      while (ready && c < 100) begin @(negedge clk); c++; end
      check("R5 no restart", c, LT);
      // R6: write during busy ignored
      wr(65, 8'hEE);
      // R7/R8/R9/R10: status reads during program
      for (int k = 0; k < 4; k++) begin
         rd(64, d, oe);
         check("R9 R8 R7 prog status", d, (k % 2 == 0) ? 8'hA0 : 8'hE0);
         check("R10 prog mask", oe, 8'hE0);
      end
      while (!ready) @(negedge clk);
      rd(64, d, oe);
      check("R8 R9 true data after done", {d, oe}, {8'h10, 8'hFF});
      c = 0;
      for (int k = 0; k < LT + 3; k++) begin @(negedge clk); if (!ready) c++; end
      check("R6 no burst from busy write", c, 0);
      read_cmp(65, "R6 busy write ignored");
      read_cmp(80, "R5 foreign data ignored");

      // R3: full-page sweep over every page
      for (int p = 0; p < DEPTH / PSZ; p++) begin
         for (int bi = 0; bi < PSZ; bi++) begin
            int a = p * PSZ + bi;
            model[a] = 8'((p * 37 + bi * 11 + 5) & 255);
            wr(a, model[a]);
         end
         wait_idle();
      end
      for (int a = 0; a < DEPTH; a++) read_cmp(a, "R3 R2 full sweep");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule